// File: doc/BRIEF.md
# Multi-Mode 16-bit Timer/Counter

This block holds a 16-bit count register and a 16-bit capture/reload register. Software configures it through a small byte-wide register file. The count advances in one of two ways. It can follow the system clock through a fixed prescaler. It can also follow falling edges seen on an external count pin, which is sampled once per machine cycle. A second external pin, the trigger pin, serves as a capture or reload strobe. In up/down operation the same pin sets the count direction instead.

Four behaviours share the one counter:
- **Capture:** a free-running count with an overflow flag, and snapshots of the count taken on trigger edges.
- **Auto-reload:** counts up only, or up and down with a programmable floor and a seventeenth toggle bit.
- **Baud tick generation:** produces separately gated receive and transmit ticks at one sixteenth of the rollover rate.
- **Clock output:** a pin that toggles on every rollover, which gives a 50% duty square wave.

Two sticky flags feed one interrupt request. Only software clears them.

Top module: `tmr16_multi`

## Requirements
- R1: After synchronous reset, every register reads zero: control at address 0, mode at address 1, count low/high at addresses 2/3, reload low/high at addresses 4/5. The interrupt, tick and clock-out outputs are low, and the trigger and count pins are assumed idle high.
- R2: The control byte has these bits, from bit 7 down: ovf flag, ext flag, rx-select, tx-select, ext-enable, run, ext-count, capture-select. With run=0 and ext-enable=0 the count holds. With run=1 in timer function, the count advances exactly once per 12 clocks.
- R3: With ext-count=1, the count pin is sampled once per 12 clocks. The count advances once for each pair of consecutive samples that reads high and then low.
- R4: Capture applies when capture-select=1 and rx-select=tx-select=0. In this mode the count wraps from FFFFh to 0000h and sets the ovf flag. With ext-enable=1, a falling trigger edge copies the count into the reload register and sets the ext flag. With ext-enable=0, trigger edges change neither.
- R5: Auto-reload applies when capture-select=0 and mode bit 0 (down-enable) is 0. Rolling over from FFFFh loads the reload register and sets the ovf flag. With ext-enable=1, a falling trigger edge also loads the reload register and sets the ext flag.
- R6: Auto-reload with down-enable=1 counts up while the trigger pin is high and down while it is low. Counting down from a value equal to the reload register loads FFFFh and sets the ovf flag. The ext flag toggles on every overflow or underflow and does not drive the interrupt.
- R7: Setting rx-select or tx-select gives baud mode, where the count advances every 2 clocks. Rollover reloads the count but never sets the ovf flag. A trigger edge with ext-enable=1 sets the ext flag without a reload. rx_tick_o pulses once per 16 rollovers only if rx-select=1, and tx_tick_o does the same for tx-select.
- R8: Mode bit 1 (clock-out enable) with ext-count=0 makes the count advance every 2 clocks. clk_out_o toggles on each rollover and changes at no other time, and these rollovers never set the ovf flag.
- R9: irq_o is the OR of the ovf flag and the ext flag, with the ext flag left out in up/down mode. Hardware only ever sets the flags. A control write is the only way to clear them.
- R10: A software write has priority in the cycle where it lands. A control write decides both flags, even against a hardware set. A count byte write decides that byte, even against a reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_pin_i | input | 1 | External count input, falling edges counted |
| trig_pin_i | input | 1 | External trigger / count-direction input |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address (0..5) |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for reg_addr_i |
| flag_ovf_o | output | 1 | Overflow/underflow flag |
| flag_ext_o | output | 1 | External event / toggle flag |
| irq_o | output | 1 | Interrupt request |
| rx_tick_o | output | 1 | Receive baud tick, one clock wide |
| tx_tick_o | output | 1 | Transmit baud tick, one clock wide |
| clk_out_o | output | 1 | Programmable square-wave output |

## Verification
The hardest case to reach from the ports is a register write that lands in exactly the cycle where hardware rolls over. The prescaler phase cannot be seen from outside, so a single write cannot be aimed at that cycle. The stimulus therefore holds the write strobe asserted for many consecutive cycles while the counter is parked at a value that rolls on every advance. This places a write in every phase, including the rollover cycle, and the output is checked on each of those cycles. The up/down floor is reached by loading a count just above the reload value with the trigger pin held low, and the expected wrap to FFFFh is worked out per advance.

// File: rtl/tmr16_pkg.sv
`timescale 1ns/1ps
package tmr16_pkg;
  localparam int CW = 16;
  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_MODE = 3'd1;
  localparam logic [2:0] A_CNTL = 3'd2;
  localparam logic [2:0] A_CNTH = 3'd3;
  localparam logic [2:0] A_CAPL = 3'd4;
  localparam logic [2:0] A_CAPH = 3'd5;
  // control byte fields
  localparam int B_OVF  = 7;
  localparam int B_EXT  = 6;
  localparam int B_RXS  = 5;
  localparam int B_TXS  = 4;
  localparam int B_XEN  = 3;
  localparam int B_RUN  = 2;
  localparam int B_XCNT = 1;
  localparam int B_CAPS = 0;
  // mode byte fields
  localparam int M_DOWN = 0;
  localparam int M_CKO  = 1;
endpackage

// File: rtl/tmr16_prescale.sv
`timescale 1ns/1ps
module tmr16_prescale #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= (cnt_q == LAST);
      cnt_q  <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/tmr16_fall.sv
`timescale 1ns/1ps
module tmr16_fall (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  input  logic strobe_i,
  output logic lvl_o,
  output logic fall_o
);
  logic [1:0] sync_q;
  logic       smp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= 2'b00;
      smp_q  <= 1'b0;
      fall_o <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], pin_i};
      fall_o <= strobe_i & smp_q & ~sync_q[1];
      if (strobe_i) smp_q <= sync_q[1];
    end
  end

  assign lvl_o = sync_q[1];
endmodule

// File: rtl/tmr16_bauddiv.sv
`timescale 1ns/1ps
module tmr16_bauddiv #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic in_i,
  output logic wrap_o
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);
  logic [W-1:0] cnt_q;

  assign wrap_o = in_i && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (in_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/tmr16_multi.sv
`timescale 1ns/1ps
module tmr16_multi
  import tmr16_pkg::*;
#(
  parameter int MC_DIV   = 12,
  parameter int FAST_DIV = 2,
  parameter int BAUD_DIV = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cnt_pin_i,
  input  logic       trig_pin_i,
  input  logic       reg_we_i,
  input  logic [2:0] reg_addr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  output logic       flag_ovf_o,
  output logic       flag_ext_o,
  output logic       irq_o,
  output logic       rx_tick_o,
  output logic       tx_tick_o,
  output logic       clk_out_o
);
  localparam logic [CW-1:0] ALL1 = '1;

  logic [7:0]    ctrl_q, ctrl_n;
  logic          down_q, oe_q;
  logic [CW-1:0] cnt_q, cnt_n, cap_q, cap_n;
  logic          mc_tick, st_tick, cnt_fall, trig_fall, trig_lvl, cnt_lvl_unused;
  logic          baud_wrap;

  tmr16_prescale #(.DIV(MC_DIV))   u_mc (.clk(clk), .rst(rst), .tick_o(mc_tick));
  tmr16_prescale #(.DIV(FAST_DIV)) u_st (.clk(clk), .rst(rst), .tick_o(st_tick));

  tmr16_fall u_cnt_edge (.clk(clk), .rst(rst), .pin_i(cnt_pin_i), .strobe_i(mc_tick),
                         .lvl_o(cnt_lvl_unused), .fall_o(cnt_fall));
  tmr16_fall u_trg_edge (.clk(clk), .rst(rst), .pin_i(trig_pin_i), .strobe_i(mc_tick),
                         .lvl_o(trig_lvl), .fall_o(trig_fall));

  // mode decode
  logic baud, capm, updown, clko, fast, run, adv, go_down, roll, trig_ev, tf_set;
  logic [CW-1:0] roll_val, step_val;

  assign baud    = ctrl_q[B_RXS] | ctrl_q[B_TXS];
  assign run     = ctrl_q[B_RUN];
  assign capm    = ~baud & ctrl_q[B_CAPS];
  assign updown  = ~baud & ~ctrl_q[B_CAPS] & down_q;
  assign clko    = oe_q & ~ctrl_q[B_XCNT];
  assign fast    = baud | clko;
  assign adv     = run & (ctrl_q[B_XCNT] ? cnt_fall : (fast ? st_tick : mc_tick));
  assign go_down = updown & ~trig_lvl;
  assign roll    = adv & (go_down ? (cnt_q == cap_q) : (cnt_q == ALL1));
  assign trig_ev = ctrl_q[B_XEN] & trig_fall & ~updown;
  assign tf_set  = roll & ~baud & ~clko;
  assign step_val = go_down ? cnt_q - 1'b1 : cnt_q + 1'b1;

  always_comb begin
    if (go_down)            roll_val = ALL1;
    else if (capm && !clko) roll_val = '0;
    else                    roll_val = cap_q;
  end

  tmr16_bauddiv #(.DIV(BAUD_DIV)) u_baud (.clk(clk), .rst(rst), .in_i(roll & baud),
                                          .wrap_o(baud_wrap));

  // next-state: hardware first, software writes last (higher priority)
  always_comb begin
    cnt_n = cnt_q;
    if (adv) cnt_n = roll ? roll_val : step_val;
    if (trig_ev && !capm && !baud) cnt_n = cap_q;
    if (reg_we_i && reg_addr_i == A_CNTL) cnt_n[7:0]  = reg_wdata_i;
    if (reg_we_i && reg_addr_i == A_CNTH) cnt_n[15:8] = reg_wdata_i;

    cap_n = cap_q;
    if (trig_ev && capm) cap_n = cnt_q;
    if (reg_we_i && reg_addr_i == A_CAPL) cap_n[7:0]  = reg_wdata_i;
    if (reg_we_i && reg_addr_i == A_CAPH) cap_n[15:8] = reg_wdata_i;

    ctrl_n = ctrl_q;
    ctrl_n[B_OVF] = ctrl_q[B_OVF] | tf_set;
    ctrl_n[B_EXT] = updown ? (ctrl_q[B_EXT] ^ roll) : (ctrl_q[B_EXT] | trig_ev);
    if (reg_we_i && reg_addr_i == A_CTRL) ctrl_n = reg_wdata_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      down_q    <= 1'b0;
      oe_q      <= 1'b0;
      cnt_q     <= '0;
      cap_q     <= '0;
      clk_out_o <= 1'b0;
      rx_tick_o <= 1'b0;
      tx_tick_o <= 1'b0;
    end else begin
      ctrl_q <= ctrl_n;
      cnt_q  <= cnt_n;
      cap_q  <= cap_n;
      if (reg_we_i && reg_addr_i == A_MODE) begin
        down_q <= reg_wdata_i[M_DOWN];
        oe_q   <= reg_wdata_i[M_CKO];
      end
      if (roll && clko) clk_out_o <= ~clk_out_o;
      rx_tick_o <= baud_wrap & ctrl_q[B_RXS];
      tx_tick_o <= baud_wrap & ctrl_q[B_TXS];
    end
  end

  always_comb begin
    case (reg_addr_i)
      A_CTRL:  reg_rdata_o = ctrl_q;
      A_MODE:  reg_rdata_o = {6'b0, oe_q, down_q};
      A_CNTL:  reg_rdata_o = cnt_q[7:0];
      A_CNTH:  reg_rdata_o = cnt_q[15:8];
      A_CAPL:  reg_rdata_o = cap_q[7:0];
      A_CAPH:  reg_rdata_o = cap_q[15:8];
      default: reg_rdata_o = 8'h00;
    endcase
  end

  assign flag_ovf_o = ctrl_q[B_OVF];
  assign flag_ext_o = ctrl_q[B_EXT];
  assign irq_o      = ctrl_q[B_OVF] | (ctrl_q[B_EXT] & ~updown);
endmodule

// File: rtl/tmr16_multi_chk.sv
`timescale 1ns/1ps
module tmr16_multi_chk (
  input logic        clk,
  input logic        rst,
  input logic        reg_we_i,
  input logic [2:0]  reg_addr_i,
  input logic [7:0]  ctrl_q,
  input logic [15:0] cnt_q,
  input logic        oe_q,
  input logic        flag_ovf_o,
  input logic        flag_ext_o,
  input logic        irq_o,
  input logic        rx_tick_o,
  input logic        tx_tick_o,
  input logic        clk_out_o
);
  AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(ctrl_q[2]) && !$past(ctrl_q[3]) && !$past(reg_we_i)) |-> $stable(cnt_q)); // R2
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    $fell(flag_ovf_o) |-> $past(reg_we_i && reg_addr_i == 3'd0)); // R9
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (flag_ovf_o || flag_ext_o)); // R9
  AST_BAUD_NO_OVF: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_ovf_o) |-> ($past(reg_we_i && reg_addr_i == 3'd0) || !$past(ctrl_q[5] || ctrl_q[4]))); // R7
  AST_RX_GATED: assert property (@(posedge clk) disable iff (rst)
    rx_tick_o |-> $past(ctrl_q[5])); // R7
  AST_TX_GATED: assert property (@(posedge clk) disable iff (rst)
    tx_tick_o |-> $past(ctrl_q[4])); // R7
  AST_CLKOUT_ONLY_ENABLED: assert property (@(posedge clk) disable iff (rst)
    !$stable(clk_out_o) |-> $past(oe_q && !ctrl_q[1])); // R8
endmodule

bind tmr16_multi tmr16_multi_chk u_chk (
  .clk(clk), .rst(rst), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
  .ctrl_q(ctrl_q), .cnt_q(cnt_q), .oe_q(oe_q), .flag_ovf_o(flag_ovf_o),
  .flag_ext_o(flag_ext_o), .irq_o(irq_o), .rx_tick_o(rx_tick_o),
  .tx_tick_o(tx_tick_o), .clk_out_o(clk_out_o)
);

// File: tb/tmr16_multi_tb.sv
`timescale 1ns/1ps
module tmr16_multi_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cnt_pin = 1'b1, trig_pin = 1'b1;
  logic       we = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       ovf, ext, irq, rxt, txt, cko;
  int checks = 0, errors = 0;
  logic [7:0] v;
  logic [15:0] w;

  always #2 clk = ~clk;  // 250 MHz

  tmr16_multi u_dut (
    .clk(clk), .rst(rst), .cnt_pin_i(cnt_pin), .trig_pin_i(trig_pin),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .flag_ovf_o(ovf), .flag_ext_o(ext), .irq_o(irq),
    .rx_tick_o(rxt), .tx_tick_o(txt), .clk_out_o(cko)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic rd16(input logic [2:0] a, output logic [15:0] d);
    logic [7:0] lo, hi;
    rd(a, lo); rd(a + 3'd1, hi); d = {hi, lo};
  endtask

  task automatic wr16(input logic [2:0] a, input logic [15:0] d);
    wr(a, d[7:0]); wr(a + 3'd1, d[15:8]);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic trig_pulse();
    trig_pin = 1'b0; idle(36); trig_pin = 1'b1; idle(36);
  endtask

  task automatic t_reset();
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v); chk(v == 8'h00, "R1 reg", v, 0);
    end
    chk({irq, rxt, txt, cko} == 4'b0, "R1 outputs", {irq, rxt, txt, cko}, 0);
  endtask

  task automatic t_timer();
    wr16(3'd2, 16'h0010);
    wr(3'd0, 8'h04);
    repeat (120) @(posedge clk);
    rd16(3'd2, w); chk(w == 16'h001A, "R2 timer rate", w, 16'h001A);
    wr(3'd0, 8'h00);
    rd16(3'd2, w); idle(60);
    begin logic [15:0] w2; rd16(3'd2, w2); chk(w2 == w, "R2 stopped hold", w2, w); end
  endtask

  task automatic t_counter();
    wr16(3'd2, 16'h0000);
    wr(3'd0, 8'h06);
    for (int i = 0; i < 5; i++) begin
      cnt_pin = 1'b0; idle(24); cnt_pin = 1'b1; idle(24);
    end
    idle(40);
    rd16(3'd2, w); chk(w == 16'd5, "R3 pin edges", w, 5);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_capture();
    wr16(3'd4, 16'h0000);
    wr16(3'd2, 16'hFFF0);
    wr(3'd0, 8'h0D);
    repeat (240) @(posedge clk);
    rd16(3'd2, w); chk(w == 16'h0004, "R4 wrap to zero", w, 4);
    rd(3'd0, v); chk(v[7] == 1'b1, "R4 ovf set", v, 8'h8D);
    idle(50);
    chk(irq == 1'b1, "R9 irq sticky", irq, 1);
    wr(3'd0, 8'h09);
    chk(irq == 1'b0 && ovf == 1'b0, "R9 software clear", {ovf, irq}, 0);
    wr16(3'd2, 16'h1234);
    trig_pulse();
    rd16(3'd4, w); chk(w == 16'h1234, "R4 capture value", w, 16'h1234);
    rd(3'd0, v); chk(v == 8'h49, "R4 ext flag", v, 8'h49);
    wr(3'd0, 8'h01);
    wr16(3'd2, 16'h5555);
    trig_pulse();
    rd16(3'd4, w); chk(w == 16'h1234, "R4 ext-enable off keeps capture", w, 16'h1234);
    rd(3'd0, v); chk(v == 8'h01, "R4 ext-enable off no flag", v, 8'h01);
  endtask

  task automatic t_reload();
    wr(3'd0, 8'h00);
    wr16(3'd4, 16'hFFF0);
    wr16(3'd2, 16'hFFFE);
    wr(3'd0, 8'h04);
    repeat (120) @(posedge clk);
    rd16(3'd2, w); chk(w == 16'hFFF8, "R5 reload on rollover", w, 16'hFFF8);
    rd(3'd0, v); chk(v == 8'h84, "R5 ovf flag", v, 8'h84);
    wr(3'd0, 8'h08);
    wr16(3'd2, 16'h0100);
    trig_pulse();
    rd16(3'd2, w); chk(w == 16'hFFF0, "R5 trigger reload", w, 16'hFFF0);
    rd(3'd0, v); chk(v == 8'h48, "R5 ext flag", v, 8'h48);
  endtask

  task automatic t_updown();
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h01);
    wr16(3'd4, 16'h0005);
    wr16(3'd2, 16'h0008);
    trig_pin = 1'b0; idle(36);
    wr(3'd0, 8'h04);
    repeat (120) @(posedge clk);
    rd16(3'd2, w); chk(w == 16'hFFF9, "R6 down through floor", w, 16'hFFF9);
    rd(3'd0, v); chk(v == 8'hC4, "R6 flags after underflow", v, 8'hC4);
    wr(3'd0, 8'h40);
    chk(irq == 1'b0, "R6 ext flag masked from irq", irq, 0);
    trig_pin = 1'b1; idle(36);
    wr16(3'd2, 16'hFFFE);
    wr(3'd0, 8'h04);
    repeat (24) @(posedge clk);
    rd16(3'd2, w); chk(w == 16'h0005, "R6 up reload", w, 5);
    rd(3'd0, v); chk(v == 8'hC4, "R6 toggle on overflow", v, 8'hC4);
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_baud();
    int nrx = 0, ntx = 0;
    wr16(3'd4, 16'hFFFC);
    wr16(3'd2, 16'hFFFC);
    wr(3'd0, 8'h34);
    for (int i = 0; i < 1100; i++) begin
      @(negedge clk); if (rxt) nrx++; if (txt) ntx++;
    end
    chk(nrx == 8, "R7 rx tick rate", nrx, 8);
    chk(ntx == 8, "R7 tx tick rate", ntx, 8);
    rd(3'd0, v); chk(v[7] == 1'b0, "R7 no ovf in baud", v, 8'h34);
    wr(3'd0, 8'h24);
    nrx = 0; ntx = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk); if (rxt) nrx++; if (txt) ntx++;
    end
    chk(ntx == 0 && nrx >= 2, "R7 tx gated off", ntx, 0);
    wr(3'd0, 8'h28);
    wr16(3'd2, 16'h1111);
    trig_pulse();
    rd16(3'd2, w); chk(w == 16'h1111, "R7 trigger no reload", w, 16'h1111);
    rd(3'd0, v); chk(v == 8'h68, "R7 trigger sets ext", v, 8'h68);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_clkout();
    int tog = 0;
    logic prev;
    wr(3'd1, 8'h02);
    wr16(3'd4, 16'hFFFE);
    wr16(3'd2, 16'hFFFE);
    wr(3'd0, 8'h04);
    prev = cko;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk); if (cko != prev) tog++; prev = cko;
    end
    chk(tog >= 98 && tog <= 101, "R8 toggle rate", tog, 100);
    rd(3'd0, v); chk(v[7] == 1'b0, "R8 no ovf in clock-out", v, 8'h04);
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_priority();
    int bad;
    wr16(3'd4, 16'hFFFF);
    wr16(3'd2, 16'hFFFF);
    @(negedge clk); we = 1'b1; addr = 3'd0; wdata = 8'h04;
    bad = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (ovf) bad++; end
    we = 1'b0;
    chk(bad == 0, "R10 flag write beats set", bad, 0);
    idle(24);
    chk(ovf == 1'b1, "R5 rollover sets ovf", ovf, 1);
    wr(3'd0, 8'h00);
    wr16(3'd4, 16'h0000);
    wr16(3'd2, 16'hFFFF);
    wr(3'd0, 8'h24);
    @(negedge clk); we = 1'b1; addr = 3'd2; wdata = 8'hFF;
    bad = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); #1 if (rdata != 8'hFF) bad++; end
    we = 1'b0;
    chk(bad == 0, "R10 count write beats reload", bad, 0);
    wr(3'd0, 8'h00);
  endtask

  initial begin
    idle(5); rst = 1'b0; idle(2);
    t_reset();
    t_timer();
    t_counter();
    t_capture();
    t_reload();
    t_updown();
    t_baud();
    t_clkout();
    t_priority();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule